// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block is the sending side of a classic byte-oriented UART. A processor writes characters and configuration through a small write-only register port. The block turns each character into an asynchronous frame on one serial line. Each frame has a start bit, 5 to 8 data bits sent least significant first, an optional parity bit, and a stop period of one, one and a half, or two bit times. The line rests high between frames.

There are two storage stages. The holding stage accepts the next character while the shift stage is still sending the current one. Two status outputs tell software whether the holding stage is free and whether the whole transmitter has gone quiet.

The bit rate comes from a 16-bit divisor. The divider produces one tick every divisor clocks, and each bit lasts sixteen ticks. A format bit can hold the line low to send a break, and the framing logic keeps running underneath it.

Top module: `async_tx`

## Requirements
- R1: While reset is asserted and right after it, serOut is 1, holdEmpty is 1 and txEmpty is 1. Reset clears the format register to 0, which selects 5 data bits, no parity and 1 stop bit.
- R2: The format register is at address 3. Its bits [1:0] select the word length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. A frame is a 0 start bit followed by the data bits, bit 0 first. Data bits above the selected length are not sent.
- R3: Format bit 3 enables parity. The parity bit is sent after the last data bit and before the stop period. With bit 5 clear, bit 4 = 1 makes the number of ones in data plus parity even, and bit 4 = 0 makes it odd.
- R4: With format bits 3 and 5 both set, the parity bit is 0 when bit 4 is 1, and 1 when bit 4 is 0.
- R5: The stop period is high. When format bit 2 is 0 it lasts 1 bit. When bit 2 is 1 it lasts 1.5 bits for 5-bit words and 2 bits for 6-, 7- and 8-bit words.
- R6: Format bit 7 opens the divisor latches. With bit 7 set, address 0 writes the divisor low byte and address 1 writes the high byte, and the holding register is not loaded. One bit lasts 16 × divisor clock cycles.
- R7: A write to address 0 with format bit 7 clear loads the holding register, and holdEmpty is 0 in the next cycle. holdEmpty returns to 1 when the character moves into an idle shift stage. While a second character waits behind a frame in progress, holdEmpty and txEmpty stay 0. txEmpty is 1 only when both stages are empty.
- R8: Format bit 6 holds serOut at 0 for as long as it is set. The frame timing still runs, so txEmpty rises at the normal frame end.
- R9: Reset leaves the divisor latches unchanged. A frame sent after reset, with no new divisor write, uses the divisor that was set before the reset.
- R10: A divisor of 0 behaves as a divisor of 1, so one bit lasts 16 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the register port |
| wrAddr | input | 3 | Register address: 0 holding or divisor low, 1 divisor high, 3 format |
| wrData | input | 8 | Write data |
| serOut | output | 1 | Serial line, high when idle |
| holdEmpty | output | 1 | Holding stage can accept a character |
| txEmpty | output | 1 | Holding and shift stages are both empty |

## Verification
Errors inside the block appear mostly on the serial line, so the bench decodes every frame at the middle of each bit period. A wrong word length, parity choice or shift order therefore shows up as a mismatched bit within one bit time of the fault. A wrong stop-length count or divider period shows as a frame-length error at the rise of txEmpty, off by at least half a bit. Faults in the holding-stage handshake show on holdEmpty in the cycle after the write or the transfer.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIVHI = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FMT   = 3'd3;

  // Frame phase, owned by the control unit
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic   load;   // move holding register into shifter
    logic   shift;  // advance shifter by one data bit
    phase_t phase;  // selects what the line carries
  } tx_strobe_t;

  // Format register layout
  typedef struct packed {
    logic       dlab;
    logic       brk;
    logic       stick;
    logic       evenSel;
    logic       parEn;
    logic       stopSel;
    logic [1:0] wordSel;
  } fmt_t;

endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             reload,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divEff;

  // zero divisor behaves as one
  assign divEff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick   = (cnt <= DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= DIV_W'(1);
    else if (reload || tick) cnt <= divEff;
    else                     cnt <= cnt - DIV_W'(1);
  end

endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       holdFull,
  input  logic [1:0] wordSel,
  input  logic       parEn,
  input  logic       stopSel,
  output tx_strobe_t strobe,
  output logic       idle
);

  localparam int HALF_TICKS = TICKS_PER_BIT / 2;
  localparam int MAX_STOP   = 2 * TICKS_PER_BIT;
  localparam int CNT_W      = $clog2(MAX_STOP + 1);

  phase_t           phase;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] curLen;
  logic [2:0]       bitIdx;
  logic [2:0]       lastIdx;
  logic             lastTick;

  always_comb begin
    lastIdx = 3'd4 + {1'b0, wordSel};
    if (phase == PH_STOP) begin
      if (!stopSel)              curLen = CNT_W'(TICKS_PER_BIT);
      else if (wordSel == 2'b00) curLen = CNT_W'(3 * HALF_TICKS);
      else                       curLen = CNT_W'(MAX_STOP);
    end else begin
      curLen = CNT_W'(TICKS_PER_BIT);
    end
    lastTick = tick && (tickCnt == curLen - CNT_W'(1));
  end

  always_comb begin
    strobe.load  = (phase == PH_IDLE) && holdFull;
    strobe.shift = lastTick && (phase == PH_DATA);
    strobe.phase = phase;
    idle         = (phase == PH_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (phase == PH_IDLE) begin
      tickCnt <= '0;
      bitIdx  <= '0;
      if (holdFull) phase <= PH_START;
    end else if (tick) begin
      if (lastTick) begin
        tickCnt <= '0;
        unique case (phase)
          PH_START: phase <= PH_DATA;
          PH_DATA: begin
            if (bitIdx == lastIdx) phase <= parEn ? PH_PAR : PH_STOP;
            else                   bitIdx <= bitIdx + 3'd1;
          end
          PH_PAR:  phase <= PH_STOP;
          default: phase <= PH_IDLE;
        endcase
      end else begin
        tickCnt <= tickCnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/async_tx_dpath.sv
module async_tx_dpath
  import async_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  tx_strobe_t        strobe,
  output logic              serOut,
  output logic              holdFull,
  output logic [1:0]        wordSel,
  output logic              parEn,
  output logic              stopSel,
  output logic              dlab,
  output logic              brk,
  output logic [DIV_W-1:0]  divisor,
  output logic              divReload
);

  localparam int HI_W = DIV_W - 8;

  fmt_t            fmt;
  logic [7:0]      holdReg;
  logic [7:0]      shiftReg;
  logic            parBit;
  logic [7:0]      divLo;
  logic [HI_W-1:0] divHi;
  logic            wrHold, wrDivLo, wrDivHi, wrFmt;
  logic [7:0]      wordMask;
  logic            rawPar, nextPar, lineBit;

  always_comb begin
    wrHold  = wrEn && (wrAddr == ADDR_DATA)  && !fmt.dlab;
    wrDivLo = wrEn && (wrAddr == ADDR_DATA)  &&  fmt.dlab;
    wrDivHi = wrEn && (wrAddr == ADDR_DIVHI) &&  fmt.dlab;
    wrFmt   = wrEn && (wrAddr == ADDR_FMT);
  end

  // parity over the selected data bits only
  always_comb begin
    wordMask = 8'hFF >> (2'd3 - fmt.wordSel);
    rawPar   = ^(holdReg & wordMask);
    if (fmt.stick)        nextPar = ~fmt.evenSel;
    else if (fmt.evenSel) nextPar = rawPar;
    else                  nextPar = ~rawPar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmt       <= '0;
      holdFull  <= 1'b0;
      divReload <= 1'b0;
    end else begin
      if (wrFmt) fmt <= fmt_t'(wrData);
      if (wrHold)           holdFull <= 1'b1;
      else if (strobe.load) holdFull <= 1'b0;
      divReload <= wrDivLo || wrDivHi;
    end
  end

  // data stores carry no reset
  always_ff @(posedge clk) begin
    if (wrHold)  holdReg <= wrData;
    if (wrDivLo) divLo   <= wrData;
    if (wrDivHi) divHi   <= wrData[HI_W-1:0];
    if (strobe.load) begin
      shiftReg <= holdReg;
      parBit   <= nextPar;
    end else if (strobe.shift) begin
      shiftReg <= {1'b0, shiftReg[7:1]};
    end
  end

  always_comb begin
    unique case (strobe.phase)
      PH_START: lineBit = 1'b0;
      PH_DATA:  lineBit = shiftReg[0];
      PH_PAR:   lineBit = parBit;
      default:  lineBit = 1'b1;
    endcase
    serOut = fmt.brk ? 1'b0 : lineBit;
  end

  assign wordSel = fmt.wordSel;
  assign parEn   = fmt.parEn;
  assign stopSel = fmt.stopSel;
  assign dlab    = fmt.dlab;
  assign brk     = fmt.brk;
  assign divisor = {divHi, divLo};

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DIV_W         = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic              serOut,
  output logic              holdEmpty,
  output logic              txEmpty
);

  tx_strobe_t       strobe;
  logic             holdFull, idle, baudTick, divReload;
  logic [1:0]       wordSel;
  logic             parEn, stopSel, dlab, brk;
  logic [DIV_W-1:0] divisor;

  async_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .divisor(divisor), .reload(divReload), .tick(baudTick)
  );

  async_tx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(baudTick), .holdFull(holdFull),
    .wordSel(wordSel), .parEn(parEn), .stopSel(stopSel),
    .strobe(strobe), .idle(idle)
  );

  async_tx_dpath #(.DIV_W(DIV_W)) u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .serOut(serOut), .holdFull(holdFull),
    .wordSel(wordSel), .parEn(parEn), .stopSel(stopSel),
    .dlab(dlab), .brk(brk), .divisor(divisor), .divReload(divReload)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = !holdFull && idle;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk
  import async_tx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              brkBit,
  input logic              serOut,
  input logic              holdEmpty,
  input logic              dlab,
  input logic              brk,
  input phase_t            phase
);

  // R7
  hold_write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_DATA && !dlab) |=> !holdEmpty);

  // R7
  hold_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdEmpty) |-> $past(wrEn && wrAddr == ADDR_DATA && !dlab));

  // R6
  latch_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_DATA && dlab && holdEmpty) |=> holdEmpty);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_START && !brk) |-> !serOut);

  // R5
  stop_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STOP && !brk) |-> serOut);

  // R8
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && wrAddr == ADDR_FMT && brkBit) |-> !serOut);

endmodule

bind async_tx async_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .brkBit(wrData[6]),
  .serOut(serOut), .holdEmpty(holdEmpty), .dlab(dlab), .brk(brk),
  .phase(strobe.phase)
);

// File: tb/async_tx_test.sv
module async_tx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       serOut, holdEmpty, txEmpty;

  async_tx uut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] fmtShadow = '0;
  int curDiv = 1;
  int pushed = 0, popped = 0;

  logic [11:0] qBits[$];
  int          qNb[$];
  int          qTicks[$];
  int          qDiv[$];
  bit          qBrk[$];
  bit          qDur[$];
  string       qTag[$];

  task automatic chkEq(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkRange(input string tag, input longint act, input longint lo, input longint hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setFmt(input logic [7:0] f);
    fmtShadow = f;
    wr(3'd3, f);
  endtask

  task automatic setDiv(input logic [15:0] d);
    wr(3'd3, fmtShadow | 8'h80);
    wr(3'd0, d[7:0]);
    wr(3'd1, d[15:8]);
    wr(3'd3, fmtShadow);
    curDiv = (d == 16'd0) ? 1 : int'(d);
  endtask

  // driver: compute the expected frame from the requirements, push, then write
  task automatic sendChar(input logic [7:0] d, input string tag, input bit dur);
    int n, idx, halves;
    logic [7:0] m;
    logic pb;
    logic [11:0] b;
    n = 5 + int'(fmtShadow[1:0]);
    m = d & (8'hFF >> (8 - n));
    if (fmtShadow[5])      pb = ~fmtShadow[4];
    else if (fmtShadow[4]) pb = ^m;
    else                   pb = ~^m;
    b = '0;
    for (int i = 0; i < n; i++) b[1+i] = m[i];
    idx = 1 + n;
    if (fmtShadow[3]) begin b[idx] = pb; idx++; end
    b[idx] = 1'b1;
    halves = !fmtShadow[2] ? 2 : ((n == 5) ? 3 : 4);
    if (fmtShadow[6]) b = '0;
    qBits.push_back(b);
    qNb.push_back(idx + 1);
    qTicks.push_back(16 * idx + 8 * halves);
    qDiv.push_back(curDiv);
    qBrk.push_back(fmtShadow[6]);
    qDur.push_back(dur);
    qTag.push_back(tag);
    pushed++;
    wr(3'd0, d);
  endtask

  task automatic waitDone();
    while (popped != pushed) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: decode each frame at mid-bit and measure its length
  initial begin
    forever begin
      logic [11:0] b;
      int nb, tk, dv, t0, bitClk;
      bit brk, dur;
      string tag;
      while (qBits.size() == 0) @(negedge clk);
      b = qBits.pop_front(); nb = qNb.pop_front(); tk = qTicks.pop_front();
      dv = qDiv.pop_front(); brk = qBrk.pop_front(); dur = qDur.pop_front();
      tag = qTag.pop_front();
      do @(negedge clk); while (brk ? txEmpty : serOut);
      t0 = cyc;
      bitClk = 16 * dv;
      for (int k = 0; k < nb; k++) begin
        while (cyc < t0 + k * bitClk + bitClk / 2) @(negedge clk);
        chkEq($sformatf("%s bit%0d", tag, k), serOut, b[k]);
      end
      if (dur) begin
        while (!txEmpty) @(negedge clk);
        chkRange({tag, " frame length"}, cyc - t0, tk * dv - dv, tk * dv + 1);
      end
      popped++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chkEq("R1 serOut in reset", serOut, 1);
    chkEq("R1 holdEmpty in reset", holdEmpty, 1);
    chkEq("R1 txEmpty in reset", txEmpty, 1);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 serOut after reset", serOut, 1);

    // R6: divisor access must not load the holding register
    setFmt(8'h03);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'd2);
    chkEq("R6 holdEmpty after latch write", holdEmpty, 1);
    chkEq("R6 txEmpty after latch write", txEmpty, 1);
    wr(3'd1, 8'd0);
    wr(3'd3, 8'h03);
    curDiv = 2;

    // R2 / R7: 8 data bits, no parity
    sendChar(8'hA5, "R2 8N1", 1);
    chkEq("R7 holdEmpty after write", holdEmpty, 0);
    @(negedge clk);
    chkEq("R7 holdEmpty after transfer", holdEmpty, 1);
    chkEq("R7 txEmpty while shifting", txEmpty, 0);
    waitDone();
    chkEq("R7 txEmpty when drained", txEmpty, 1);

    // R2: 5 data bits, upper bits dropped
    setFmt(8'h00);
    sendChar(8'h35, "R2 5N1", 1);
    waitDone();

    // R3: even and odd parity on 7 bits
    setFmt(8'h1A);
    sendChar(8'h53, "R3 7E1", 1);
    waitDone();
    setFmt(8'h0A);
    sendChar(8'h53, "R3 7O1", 1);
    waitDone();

    // R4: stick parity
    setFmt(8'h3B);
    sendChar(8'hFF, "R4 stick zero", 1);
    waitDone();
    setFmt(8'h2B);
    sendChar(8'h00, "R4 stick one", 1);
    waitDone();

    // R5: long stop periods
    setFmt(8'h04);
    sendChar(8'h0A, "R5 5-bit 1.5 stop", 1);
    waitDone();
    setFmt(8'h05);
    sendChar(8'h2C, "R5 6-bit 2 stop", 1);
    waitDone();

    // R7: back-to-back characters
    setFmt(8'h03);
    sendChar(8'h11, "R7 first", 0);
    while (!holdEmpty) @(negedge clk);
    sendChar(8'h22, "R7 second", 1);
    chkEq("R7 holdEmpty with char waiting", holdEmpty, 0);
    repeat (40) @(negedge clk);
    chkEq("R7 holdEmpty still waiting", holdEmpty, 0);
    chkEq("R7 txEmpty still busy", txEmpty, 0);
    waitDone();
    chkEq("R7 holdEmpty drained", holdEmpty, 1);

    // R8: break holds the line low, timing continues
    setFmt(8'h43);
    sendChar(8'h5A, "R8 break", 1);
    waitDone();
    chkEq("R8 line low while break set", serOut, 0);
    setFmt(8'h03);
    @(negedge clk);
    chkEq("R8 line high after break", serOut, 1);

    // R10: zero divisor
    setDiv(16'd0);
    sendChar(8'h3C, "R10 divisor zero", 1);
    waitDone();

    // R9 / R1: reset keeps divisor, clears format
    setDiv(16'd3);
    setFmt(8'h1B);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R1 serOut in second reset", serOut, 1);
    chkEq("R1 holdEmpty in second reset", holdEmpty, 1);
    rstN = 1'b1;
    fmtShadow = 8'h00;
    @(negedge clk);
    sendChar(8'h0F, "R9 R1 after reset", 1);
    waitDone();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule